// File: doc/BRIEF.md
# Remapped-Vector Interrupt Controller

This block collects 64 level-sensitive interrupt sources into two 32-bit register banks, a high bank and a low bank. Each bank has a mask register and a pending register. A source number does not correspond directly to a bit number. A fixed lookup scatters the sources across both banks, so a given bit position can hold sources from unrelated parts of the numbering.

Software enables sources by setting mask bits. It acknowledges a source by writing ones to the pending register. It can read a vector register to find the lowest-numbered source that is both pending and enabled. A single request line tells the CPU that at least one enabled source is pending.

The register port is a plain synchronous interface. Writes take effect at the rising clock edge. Read data is a combinational function of the address and the current register state. Reading any register, including the vector register, changes no state.

Top module: `remap_pic`

## Requirements
- R1: While `rst` is high, and after any clock edge at which `rst` was high, both mask registers and both pending registers read 0, `irq_req` is low, and the vector register reads 0.
- R2: A pending bit becomes 1 after any clock edge at which a source mapped to it is high, whether or not its mask bit is set. A pending bit never becomes 1 without such a source.
- R3: A write to a pending register (high bank at address 2, low bank at address 3) clears each bit written as 1 and leaves each bit written as 0 unchanged. If a mapped source is still high at that edge, the bit is set again; setting wins over clearing.
- R4: A mask register (high bank at address 0, low bank at address 1) takes the written value and reads it back. It changes only when written. A mask bit of 1 enables the matching pending bit, and 0 blocks it.
- R5: Source 0 maps to low-bank bit 0. Source v in the range 1 to 15 maps to low-bank bit 16−v.
- R6: Sources 16, 17 and 18 map to high-bank bits 2, 1 and 0. Source v in the range 19 to 30 maps to high-bank bit 33−v. Source 31 shares high-bank bit 0 with source 18. High-bank bit 15 has no source.
- R7: Source v in the range 32 to 47 maps to low-bank bit 63−v. Source v in the range 48 to 63 maps to high-bank bit v−32.
- R8: The vector register (address 4) holds a 6-bit code in bits [31:26] and zeros in bits [25:0]. The code is the lowest source number v ≥ 1 whose mapped pending bit and mask bit are both 1. When no such source exists, the code is 0. Source 0 never produces a nonzero code, and source 31 never wins over source 18 because they share a bit.
- R9: `irq_req` is high exactly when some bit is 1 in both the pending and the mask register of the same bank. It follows register changes in the same cycle, with no further delay.
- R10: Reading the vector register, or any other register, leaves the mask and pending registers unchanged.
- R11: Addresses 5 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 64 | Level source inputs, indexed by source number |
| reg_addr | input | 3 | Register select |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_req | output | 1 | Request to the CPU |

## Verification
The assertions assume the following about the inputs. `rst` is high from time zero until after the first rising edge. `src_lvl`, `reg_we`, `reg_addr` and `reg_wdata` always carry known values, so the `$past` terms and the checks of pending-bit origin and write-one-to-clear compare defined data.

The stimulus drives every input only on the falling clock edge and holds reset across several rising edges at the start. Each source is raised for a whole clock period, so the edge that captures it sees a settled level. When a test holds a source high through an acknowledge, it does so deliberately, to exercise the rule that setting wins over clearing.

// File: rtl/rvic_pkg.sv
package rvic_pkg;

    parameter int NUM_SRC  = 64;
    parameter int BANK_W   = 32;
    parameter int NUM_BANK = 2;
    parameter int CODE_W   = $clog2(NUM_SRC);
    parameter int ADDR_W   = 3;
    parameter int CODE_LSB = BANK_W - CODE_W;

    // Register select codes; index 1 of a bank array is the high bank
    parameter logic [ADDR_W-1:0] A_MASK_HI = 3'd0;
    parameter logic [ADDR_W-1:0] A_MASK_LO = 3'd1;
    parameter logic [ADDR_W-1:0] A_PEND_HI = 3'd2;
    parameter logic [ADDR_W-1:0] A_PEND_LO = 3'd3;
    parameter logic [ADDR_W-1:0] A_VECTOR  = 3'd4;

    typedef logic [NUM_BANK-1:0][BANK_W-1:0] bank_arr_t;

    typedef struct packed {
        logic       high;
        logic [4:0] pos;
    } src_loc_t;

    // Fixed scatter of source numbers onto bank bits
    function automatic src_loc_t src_locate(input int unsigned v);
        src_loc_t loc;
        if (v == 0) begin
            loc.high = 1'b0; loc.pos = 5'd0;
        end else if (v < 16) begin
            loc.high = 1'b0; loc.pos = 5'(16 - v);
        end else if (v < 19) begin
            loc.high = 1'b1; loc.pos = 5'(18 - v);
        end else if (v < 31) begin
            loc.high = 1'b1; loc.pos = 5'(33 - v);
        end else if (v == 31) begin
            loc.high = 1'b1; loc.pos = 5'd0;
        end else if (v < 48) begin
            loc.high = 1'b0; loc.pos = 5'(63 - v);
        end else begin
            loc.high = 1'b1; loc.pos = 5'(v - 32);
        end
        return loc;
    endfunction

endpackage

// File: rtl/rvic_src_router.sv
module rvic_src_router
    import rvic_pkg::*;
(
    input  logic [NUM_SRC-1:0] src,
    output bank_arr_t          set_bank
);
    always_comb begin
        set_bank = '0;
        for (int v = 0; v < NUM_SRC; v++) begin
            if (src[v]) begin
                set_bank[src_locate(v).high][src_locate(v).pos] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rvic_bank_regs.sv
module rvic_bank_regs
    import rvic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic              pend_we,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] set_in,
    output logic [BANK_W-1:0] mask_q,
    output logic [BANK_W-1:0] pend_q
);
    logic [BANK_W-1:0] clr_vec;
    logic [BANK_W-1:0] pend_d;

    assign clr_vec = pend_we ? wdata : '0;
    // set wins over clear so a held level re-arms at once
    assign pend_d  = (pend_q & ~clr_vec) | set_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            pend_q <= '0;
        end else begin
            if (mask_we) mask_q <= wdata;
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/rvic_vec_pick.sv
module rvic_vec_pick
    import rvic_pkg::*;
(
    input  bank_arr_t         mask_bank,
    input  bank_arr_t         pend_bank,
    output logic [CODE_W-1:0] code,
    output logic              any_req
);
    bank_arr_t          live;
    logic [NUM_SRC-1:0] elig;

    assign live    = mask_bank & pend_bank;
    assign any_req = |live;

    always_comb begin
        elig = '0;
        for (int v = 1; v < NUM_SRC; v++) begin
            elig[v] = live[src_locate(v).high][src_locate(v).pos];
        end
    end

    // Scan downward so the lowest eligible number is written last
    always_comb begin
        code = '0;
        for (int v = NUM_SRC - 1; v >= 1; v--) begin
            if (elig[v]) code = CODE_W'(v);
        end
    end
endmodule

// File: rtl/remap_pic.sv
module remap_pic
    import rvic_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_lvl,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [BANK_W-1:0]   reg_wdata,
    output logic [BANK_W-1:0]   reg_rdata,
    output logic                irq_req
);
    bank_arr_t         set_bank;
    bank_arr_t         mask_bank;
    bank_arr_t         pend_bank;
    logic [CODE_W-1:0] vec_code;

    rvic_src_router u_router (
        .src      (src_lvl),
        .set_bank (set_bank)
    );

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] MASK_A = (b == 1) ? A_MASK_HI : A_MASK_LO;
        localparam logic [ADDR_W-1:0] PEND_A = (b == 1) ? A_PEND_HI : A_PEND_LO;
        rvic_bank_regs u_regs (
            .clk     (clk),
            .rst     (rst),
            .mask_we (reg_we && reg_addr == MASK_A),
            .pend_we (reg_we && reg_addr == PEND_A),
            .wdata   (reg_wdata),
            .set_in  (set_bank[b]),
            .mask_q  (mask_bank[b]),
            .pend_q  (pend_bank[b])
        );
    end

    rvic_vec_pick u_pick (
        .mask_bank (mask_bank),
        .pend_bank (pend_bank),
        .code      (vec_code),
        .any_req   (irq_req)
    );

    always_comb begin
        case (reg_addr)
            A_MASK_HI: reg_rdata = mask_bank[1];
            A_MASK_LO: reg_rdata = mask_bank[0];
            A_PEND_HI: reg_rdata = pend_bank[1];
            A_PEND_LO: reg_rdata = pend_bank[0];
            A_VECTOR:  reg_rdata = {vec_code, {CODE_LSB{1'b0}}};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rvic_checker.sv
module rvic_checker
    import rvic_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                we,
    input logic [ADDR_W-1:0]   addr,
    input logic [BANK_W-1:0]   wdata,
    input bank_arr_t           set_bank,
    input bank_arr_t           mask_bank,
    input bank_arr_t           pend_bank,
    input logic [CODE_W-1:0]   vec_code,
    input logic                irq_req
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_bank == '0 && pend_bank == '0 && !irq_req));

    p_pend_origin_r2: assert property (@(posedge clk) disable iff (rst)
        (pend_bank & ~$past(pend_bank | set_bank)) == '0);

    p_w1c_lo_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && $past(addr) == A_PEND_LO) |->
        (pend_bank[0] & $past(wdata) & ~$past(set_bank[0])) == '0);

    p_w1c_hi_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && $past(addr) == A_PEND_HI) |->
        (pend_bank[1] & $past(wdata) & ~$past(set_bank[1])) == '0);

    p_mask_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(we && (addr == A_MASK_HI || addr == A_MASK_LO)) |=> $stable(mask_bank));

    p_code_needs_req_r8: assert property (@(posedge clk) disable iff (rst)
        (vec_code != '0) |-> irq_req);

    p_req_match_r9: assert property (@(posedge clk) disable iff (rst)
        irq_req == (|(pend_bank & mask_bank)));
endmodule

bind remap_pic rvic_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .set_bank  (set_bank),
    .mask_bank (mask_bank),
    .pend_bank (pend_bank),
    .vec_code  (vec_code),
    .irq_req   (irq_req)
);

// File: tb/tb_remap_pic.sv
`timescale 1ns/1ps
module tb_remap_pic;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_lvl = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    remap_pic dut (
        .clk       (clk),
        .rst       (rst),
        .src_lvl   (src_lvl),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_req   (irq_req)
    );

    // entry: {source[11:6], high bank[5], bit[4:0]}
    localparam int NT = 12;
    localparam logic [11:0] MAP_TBL [NT] = '{
        {6'd0,  1'b0, 5'd0},  {6'd1,  1'b0, 5'd15}, {6'd8,  1'b0, 5'd8},
        {6'd15, 1'b0, 5'd1},  {6'd16, 1'b1, 5'd2},  {6'd18, 1'b1, 5'd0},
        {6'd19, 1'b1, 5'd14}, {6'd30, 1'b1, 5'd3},  {6'd32, 1'b0, 5'd31},
        {6'd47, 1'b0, 5'd16}, {6'd48, 1'b1, 5'd16}, {6'd63, 1'b1, 5'd31}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [63:0] s);
        @(negedge clk);
        src_lvl = s;
        @(negedge clk);
        src_lvl = '0;
    endtask

    task automatic clear_all();
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d2;
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk("R1 reg after reset", d, 32'h0);
        end
        chk("R1 irq after reset", {31'b0, irq_req}, 32'h0);
        rst = 1'b0;

        // R2 / R9: masked source still latches, no request
        pulse(64'h1 << 5);
        rd(3'd3, d);
        chk("R2 pend while masked", d, 32'h1 << 11);
        chk("R9 masked gives no irq", {31'b0, irq_req}, 32'h0);
        rd(3'd4, d);
        chk("R8 masked gives code 0", d, 32'h0);

        // R4: mask write and readback, enables request
        wr(3'd1, 32'h1 << 11);
        rd(3'd1, d);
        chk("R4 mask readback", d, 32'h1 << 11);
        chk("R9 unmasked irq", {31'b0, irq_req}, 32'h1);
        rd(3'd4, d);
        chk("R8 code for 5", d, 32'd5 << 26);

        // R10: vector reads have no side effect
        rd(3'd4, d);
        rd(3'd3, d2);
        chk("R10 pend after vector reads", d2, 32'h1 << 11);

        // R3: writing zero keeps bits
        wr(3'd3, 32'h0);
        rd(3'd3, d);
        chk("R3 zero write keeps", d, 32'h1 << 11);

        // R8: priority with 40 (low bit 23) also pending
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd0, 32'hFFFF_FFFF);
        pulse(64'h1 << 40);
        rd(3'd4, d);
        chk("R8 lowest wins", d, 32'd5 << 26);
        wr(3'd3, 32'h1 << 11);
        rd(3'd4, d);
        chk("R8 next after clear", d, 32'd40 << 26);
        clear_all();

        // R3: held source re-sets over an acknowledge
        @(negedge clk);
        src_lvl = 64'h1 << 5;
        wr(3'd3, 32'h1 << 11);
        rd(3'd3, d);
        chk("R3 held level re-sets", d, 32'h1 << 11);
        src_lvl = '0;
        wr(3'd3, 32'h1 << 11);
        rd(3'd3, d);
        chk("R3 clear after release", d, 32'h0);

        // R5 R6 R7: mapping table
        for (int i = 0; i < NT; i++) begin
            logic [5:0]  v;
            logic        hb;
            logic [4:0]  bp;
            logic [31:0] ehi, elo;
            {v, hb, bp} = MAP_TBL[i];
            ehi = hb ? (32'h1 << bp) : 32'h0;
            elo = hb ? 32'h0 : (32'h1 << bp);
            clear_all();
            pulse(64'h1 << v);
            rd(3'd2, d);
            chk(v < 16 ? "R5 map high bank" : (v < 32 ? "R6 map high bank" : "R7 map high bank"), d, ehi);
            rd(3'd3, d);
            chk(v < 16 ? "R5 map low bank" : (v < 32 ? "R6 map low bank" : "R7 map low bank"), d, elo);
            rd(3'd4, d);
            chk("R8 code per source", d, {v, 26'h0});
            chk("R9 irq per source", {31'b0, irq_req}, 32'h1);
        end
        clear_all();
        chk("R9 irq after clear", {31'b0, irq_req}, 32'h0);

        // R6 / R8: source 31 aliases onto 18's bit
        pulse(64'h1 << 31);
        rd(3'd2, d);
        chk("R6 source 31 bit", d, 32'h1);
        rd(3'd4, d);
        chk("R8 alias reports 18", d, 32'd18 << 26);
        clear_all();

        // R11: unused address
        wr(3'd6, 32'h0);
        rd(3'd6, d);
        chk("R11 unused reads zero", d, 32'h0);
        rd(3'd1, d);
        chk("R11 mask unchanged", d, 32'hFFFF_FFFF);

        // R4: mask cleared blocks pending again
        wr(3'd1, 32'h0);
        pulse(64'h1 << 3);
        chk("R4 cleared mask blocks", {31'b0, irq_req}, 32'h0);

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rd(3'd3, d);
        chk("R1 pend after reset", d, 32'h0);
        rd(3'd0, d);
        chk("R1 mask after reset", d, 32'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule